// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is a general-purpose up-counting timer. Its counter width is a parameter (32 bits by default). A selected tick source, divided by a 12-bit prescaler, advances the counter. Three compare registers watch the counter. Each sets its own status flag when the counter reaches its value. A fourth flag marks the counter wrapping from all ones to zero. The status flags are masked by an interrupt-enable register and combined into one level-sensitive interrupt line.

Software programs the block through a simple word-addressed register bus. A write is a single-cycle strobe, and the read data is a combinational view of the addressed word.

The counter runs in one of two modes. In free-running mode it wraps at its maximum. In restart mode it returns to zero after it matches compare channel 1. A software-reset bit clears the working state but keeps the enable, clock-select and low-power option bits. The tick sources are plain one-cycle enables in the block's own clock domain.

Top module: `cmp_timer3`

Register word offsets: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2, 9 counter.

Control bits: 0 enable, 1 enable-mode, 3 stop, 5 wait, 8:6 clock select, 9 free-run, 15 software reset, 16 doze, 17 debug.

Status and interrupt-enable bits: 0/1/2 compare 1/2/3, 3/4 capture 1/2, 5 rollover.

## Requirements
- R1: After hardware reset, control, prescaler, status, interrupt enable and counter read 0, all three compare registers read all ones, and irq is low.
- R2: Capture words (offsets 7, 8) and unmapped offsets (10 to 15) read as zero, and writes to them have no effect.
- R3: Control bits 2, 4 and 10 to 14 (mask 0x7C14) always read as zero; all other written control bits read back as written.
- R4: The prescaler keeps its low 12 bits. With value P, the counter advances once per P+1 ticks of the selected source.
- R5: Clock-select code 0 freezes the counter. Code k (1 to 7) takes ticks only from input src_tick[k-1].
- R6: A compare flag is set on the clock edge where the counter takes a value equal to that compare register, whatever the interrupt enables are.
- R7: In restart mode (control bit 9 clear), the counter goes to 0 on the advance that follows a match with compare channel 1.
- R8: When the counter advances from all ones it wraps to 0 and sets status bit 5.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A flag event in the same cycle as its clear leaves the flag set.
- R10: The interrupt-enable register keeps its low 6 bits. irq is high exactly when control bit 0 is set and (status AND interrupt enable) is nonzero.
- R11: Setting control bit 0 from 0 with bit 1 set clears the counter. Setting it from 0 with bit 1 clear resumes from the held value. Clearing bit 0 holds the counter.
- R12: Writing compare channel 1 while in restart mode clears the counter.
- R13: Writing control with bit 15 set shows that bit for one cycle. On the next edge the control register is ANDed with 0x000301EB, prescaler, status, interrupt enable and counter are cleared, and the compare registers are loaded with all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| src_tick | input | 7 | Tick enables, selected by clock-select code minus one |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
- **Writes:** a register write shows on bus_rdata right after the edge that samples the strobe.
- **Ticks:** a tick that completes a prescaler period moves the counter and any compare or rollover flag on that same edge.
- **Interrupt:** irq follows the registers with no further delay.
- **Software reset:** it takes two edges, one to latch the bit and one to apply it.

The bench drives every input just after a falling edge and samples 2 ns after a falling edge. Each check therefore sees the state exactly one or more whole edges after its stimulus and never races a rising edge. The pending software-reset cycle is checked without waiting a cycle, so that the one-cycle visibility of the bit is observed.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
   localparam int DATA_W = 32;
   localparam int FLAG_W = 6;
   localparam int NCMP   = 3;
   localparam int CSEL_W = 3;
   localparam int NSRC   = (1 << CSEL_W) - 1;
   localparam int NREG   = 10;

   // register word offsets
   localparam int OFF_CTRL = 0;
   localparam int OFF_PRE  = 1;
   localparam int OFF_STAT = 2;
   localparam int OFF_IEN  = 3;
   localparam int OFF_CMP1 = 4;
   localparam int OFF_CAP1 = 7;
   localparam int OFF_CAP2 = 8;
   localparam int OFF_CNT  = 9;

   // control bit positions
   localparam int CB_EN     = 0;
   localparam int CB_ENMOD  = 1;
   localparam int CB_CSEL   = 6;
   localparam int CB_FRR    = 9;
   localparam int CB_SWR    = 15;

   localparam logic [DATA_W-1:0] CTRL_RO_MASK   = 32'h0000_7C14;
   localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h0003_01EB;

   // status / enable bit positions
   localparam int FB_CMP1 = 0;
   localparam int FB_ROV  = 5;
endpackage

// File: rtl/ctm_tick_sel.sv
module ctm_tick_sel
   import ctm_pkg::*;
(
   input  logic [NSRC-1:0]   src_tick,
   input  logic [CSEL_W-1:0] csel,
   output logic              tick
);
   logic [NSRC-1:0] hit;

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      assign hit[k] = src_tick[k] && (csel == CSEL_W'(k + 1));
   end

   assign tick = |hit;
endmodule

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic [PRE_W-1:0] div,
   output logic             step
);
   logic [PRE_W-1:0] phase;
   logic             last;

   // >= so that lowering the divider mid-period never strands the phase
   assign last = (phase >= div);
   assign step = run && tick && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (clr)
         phase <= '0;
      else if (run && tick)
         phase <= last ? '0 : phase + 1'b1;
   end
endmodule

// File: rtl/ctm_count_core.sv
module ctm_count_core
   import ctm_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       step,
   input  logic                       free_run,
   input  logic [NCMP-1:0][CNT_W-1:0] ocr,
   output logic [CNT_W-1:0]           cnt,
   output logic [NCMP-1:0]            hit,
   output logic                       wrap
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic             restart;
   logic             adv;
   logic [CNT_W-1:0] nxt;

   assign restart = !free_run && (cnt == ocr[0]);
   assign nxt     = restart ? '0 : cnt + 1'b1;
   assign adv     = step && !clr;
   assign wrap    = adv && (cnt == TOP);

   for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      assign hit[k] = adv && (nxt == ocr[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (adv)
         cnt <= nxt;
   end
endmodule

// File: rtl/ctm_regs.sv
module ctm_regs
   import ctm_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 12,
   parameter int ADDR_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [FLAG_W-1:0]          flag_set,
   input  logic [CNT_W-1:0]           cnt,
   output logic [DATA_W-1:0]          rdata,
   output logic [DATA_W-1:0]          ctrl,
   output logic [PRE_W-1:0]           pre,
   output logic [FLAG_W-1:0]          ien,
   output logic [FLAG_W-1:0]          stat,
   output logic [NCMP-1:0][CNT_W-1:0] ocr,
   output logic                       cnt_clr
);
   logic            swr_pend;
   logic [NREG-1:0] sel;
   logic            en_rise;
   logic            cmp1_restart;

   assign swr_pend = ctrl[CB_SWR];

   for (genvar k = 0; k < NREG; k++) begin : g_dec
      assign sel[k] = wr && !swr_pend && (addr == ADDR_W'(k));
   end

   assign en_rise      = sel[OFF_CTRL] && !ctrl[CB_EN] && wdata[CB_EN] && wdata[CB_ENMOD];
   assign cmp1_restart = sel[OFF_CMP1] && !ctrl[CB_FRR];
   assign cnt_clr      = swr_pend || en_rise || cmp1_restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= '0;
      else if (swr_pend)
         ctrl <= ctrl & CTRL_KEEP_MASK;
      else if (sel[OFF_CTRL])
         ctrl <= wdata & ~CTRL_RO_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre <= '0;
      else if (swr_pend)
         pre <= '0;
      else if (sel[OFF_PRE])
         pre <= wdata[PRE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ien <= '0;
      else if (swr_pend)
         ien <= '0;
      else if (sel[OFF_IEN])
         ien <= wdata[FLAG_W-1:0];
   end

   // write-one-to-clear; a new event in the same cycle wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat <= '0;
      else if (swr_pend)
         stat <= '0;
      else
         stat <= (stat & ~(sel[OFF_STAT] ? wdata[FLAG_W-1:0] : '0)) | flag_set;
   end

   for (genvar k = 0; k < NCMP; k++) begin : g_ocr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ocr[k] <= '1;
         else if (swr_pend)
            ocr[k] <= '1;
         else if (sel[OFF_CMP1 + k])
            ocr[k] <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(OFF_CTRL):     rdata = ctrl;
         ADDR_W'(OFF_PRE):      rdata = DATA_W'(pre);
         ADDR_W'(OFF_STAT):     rdata = DATA_W'(stat);
         ADDR_W'(OFF_IEN):      rdata = DATA_W'(ien);
         ADDR_W'(OFF_CMP1):     rdata = DATA_W'(ocr[0]);
         ADDR_W'(OFF_CMP1 + 1): rdata = DATA_W'(ocr[1]);
         ADDR_W'(OFF_CMP1 + 2): rdata = DATA_W'(ocr[2]);
         ADDR_W'(OFF_CAP1):     rdata = '0;
         ADDR_W'(OFF_CAP2):     rdata = '0;
         ADDR_W'(OFF_CNT):      rdata = DATA_W'(cnt);
         default:               rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmp_timer3.sv
module cmp_timer3
   import ctm_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 12,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("cmp_timer3: CNT_W must lie in 2..32");
   end
   if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre
      $error("cmp_timer3: PRE_W must lie in 1..32");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr
      $error("cmp_timer3: ADDR_W too narrow for the register map");
   end

   logic [DATA_W-1:0]          ctrl_q;
   logic [PRE_W-1:0]           pre_q;
   logic [FLAG_W-1:0]          ien_q;
   logic [FLAG_W-1:0]          stat_q;
   logic [NCMP-1:0][CNT_W-1:0] ocr_q;
   logic [CNT_W-1:0]           cnt_q;
   logic                       cnt_clr;
   logic                       tick;
   logic                       step;
   logic [NCMP-1:0]            cmp_hit;
   logic                       wrap;
   logic [FLAG_W-1:0]          flag_set;

   always_comb begin
      flag_set = '0;
      flag_set[FB_CMP1 +: NCMP] = cmp_hit;
      flag_set[FB_ROV]          = wrap;
   end

   ctm_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .flag_set(flag_set), .cnt(cnt_q), .rdata(bus_rdata), .ctrl(ctrl_q),
      .pre(pre_q), .ien(ien_q), .stat(stat_q), .ocr(ocr_q), .cnt_clr(cnt_clr)
   );

   ctm_tick_sel u_sel (
      .src_tick(src_tick), .csel(ctrl_q[CB_CSEL +: CSEL_W]), .tick(tick)
   );

   ctm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(ctrl_q[CB_EN]),
      .tick(tick), .div(pre_q), .step(step)
   );

   ctm_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(step),
      .free_run(ctrl_q[CB_FRR]), .ocr(ocr_q), .cnt(cnt_q), .hit(cmp_hit), .wrap(wrap)
   );

   assign irq = ctrl_q[CB_EN] && |(stat_q & ien_q);
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [2:0]       csel,
   input logic             free_run,
   input logic             swr,
   input logic [5:0]       stat,
   input logic [CNT_W-1:0] ocr1,
   input logic [CNT_W-1:0] ocr2,
   input logic [CNT_W-1:0] cnt,
   input logic             step,
   input logic             cnt_clr,
   input logic             irq
);
   localparam logic [CNT_W-1:0] TOP = '1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + ONE) || (cnt == '0));

   a_r5_no_source_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (csel == 3'd0 && !cnt_clr) |=> $stable(cnt));

   a_r6_cmp2_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_clr && free_run && (cnt + ONE == ocr2)) |=> stat[1]);

   a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_clr && !free_run && cnt == ocr1) |=> (cnt == '0));

   a_r8_rollover: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_clr && cnt == TOP) |=> (cnt == '0 && stat[5]));

   a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> en);

   a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_clr) |=> $stable(cnt));

   a_r13_swr_applies: assert property (@(posedge clk) disable iff (!rst_n)
      swr |=> (!swr && stat == 6'd0 && cnt == '0));
endmodule

bind cmp_timer3 ctm_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl_q[0]), .csel(ctrl_q[8:6]),
   .free_run(ctrl_q[9]), .swr(ctrl_q[15]), .stat(stat_q), .ocr1(ocr_q[0]),
   .ocr2(ocr_q[1]), .cnt(cnt_q), .step(step), .cnt_clr(cnt_clr), .irq(irq)
);

// File: tb/sim_cmp_timer3.sv
module sim_cmp_timer3;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  src_tick = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   cmp_timer3 #(.CNT_W(8), .PRE_W(12), .ADDR_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [1:0] OP_W = 2'd0, OP_C = 2'd1, OP_T = 2'd2;
   localparam int NV = 30;
   // {op, addr/source, data/count, expected, requirement number}
   localparam logic [73:0] VECS [NV] = '{
      {OP_W, 4'd3,  32'hFFFF_FFFF, 32'h0,         4'd10}, // R10
      {OP_C, 4'd3,  32'h0,         32'h0000_003F, 4'd10}, // R10
      {OP_W, 4'd3,  32'h0,         32'h0,         4'd10},
      {OP_W, 4'd0,  32'hFFFF_7FFF, 32'h0,         4'd3},  // R3
      {OP_C, 4'd0,  32'h0,         32'hFFFF_03EB, 4'd3},  // R3
      {OP_W, 4'd0,  32'h0,         32'h0,         4'd3},
      {OP_W, 4'd1,  32'hFFFF_F123, 32'h0,         4'd4},  // R4
      {OP_C, 4'd1,  32'h0,         32'h0000_0123, 4'd4},  // R4
      {OP_W, 4'd1,  32'h2,         32'h0,         4'd4},
      {OP_W, 4'd10, 32'h55,        32'h0,         4'd2},  // R2
      {OP_C, 4'd10, 32'h0,         32'h0,         4'd2},  // R2
      {OP_W, 4'd7,  32'hAAAA,      32'h0,         4'd2},
      {OP_C, 4'd7,  32'h0,         32'h0,         4'd2},  // R2
      {OP_C, 4'd8,  32'h0,         32'h0,         4'd2},  // R2
      {OP_W, 4'd0,  32'h243,       32'h0,         4'd11}, // R11
      {OP_C, 4'd9,  32'h0,         32'h0,         4'd11},
      {OP_T, 4'd0,  32'd3,         32'h0,         4'd4},
      {OP_C, 4'd9,  32'h0,         32'h1,         4'd4},  // R4
      {OP_T, 4'd0,  32'd6,         32'h0,         4'd4},
      {OP_C, 4'd9,  32'h0,         32'h3,         4'd4},  // R4
      {OP_T, 4'd1,  32'd5,         32'h0,         4'd5},
      {OP_C, 4'd9,  32'h0,         32'h3,         4'd5},  // R5
      {OP_W, 4'd0,  32'h283,       32'h0,         4'd5},
      {OP_T, 4'd1,  32'd3,         32'h0,         4'd5},
      {OP_C, 4'd9,  32'h0,         32'h4,         4'd5},  // R5
      {OP_W, 4'd0,  32'h203,       32'h0,         4'd5},
      {OP_T, 4'd0,  32'd6,         32'h0,         4'd5},
      {OP_C, 4'd9,  32'h0,         32'h4,         4'd5},  // R5
      {OP_W, 4'd0,  32'h0,         32'h0,         4'd5},
      {OP_W, 4'd1,  32'h0,         32'h0,         4'd4}
   };

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic ticks(input int idx, input int n);
      @(negedge clk);
      src_tick[idx] = 1'b1;
      repeat (n) @(negedge clk);
      src_tick[idx] = 1'b0;
   endtask

   task automatic judge(input logic [31:0] act, input logic [31:0] e, input string tag);
      n_cmp++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   task automatic chk_now(input logic [3:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      #2;
      judge(bus_rdata, e, tag);
   endtask

   task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      chk_now(a, e, tag);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      #2;
      judge({31'd0, irq}, {31'd0, e}, tag);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 hardware reset state
      chk(4'd0, 32'h0, "R1 ctrl");
      chk(4'd1, 32'h0, "R1 pre");
      chk(4'd2, 32'h0, "R1 stat");
      chk(4'd3, 32'h0, "R1 ien");
      chk(4'd4, 32'hFF, "R1 cmp1");
      chk(4'd5, 32'hFF, "R1 cmp2");
      chk(4'd6, 32'hFF, "R1 cmp3");
      chk(4'd9, 32'h0, "R1 cnt");
      chk_irq(1'b0, "R1 irq");

      for (int i = 0; i < NV; i++) begin
         logic [73:0] v;
         v = VECS[i];
         case (v[73:72])
            OP_W: wr(v[71:68], v[67:36]);
            OP_T: ticks(int'(v[71:68]), int'(v[67:36]));
            default: chk(v[71:68], v[35:4], $sformatf("R%0d row %0d", v[3:0], i));
         endcase
      end

      // R6 R9 R10: flag without enable, masking, write-one-to-clear
      wr(4'd0, 32'h243);
      chk(4'd9, 32'h0, "R11 enable-mode clear");
      wr(4'd5, 32'h5);
      ticks(0, 5);
      chk(4'd9, 32'h5, "R4 count");
      chk(4'd2, 32'h02, "R6 flag with ien off");
      chk_irq(1'b0, "R10 masked");
      wr(4'd3, 32'h2);
      chk_irq(1'b1, "R10 unmasked");
      wr(4'd2, 32'h0);
      chk(4'd2, 32'h02, "R9 write zero keeps");
      wr(4'd2, 32'h2);
      chk(4'd2, 32'h0, "R9 write one clears");
      chk_irq(1'b0, "R10 cleared");

      // R9 set wins over same-cycle clear
      wr(4'd6, 32'h6);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h4; src_tick[0] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; src_tick[0] = 1'b0;
      chk(4'd2, 32'h04, "R9 set wins");
      chk(4'd9, 32'h6, "R6 cnt at cmp3");
      wr(4'd2, 32'h3F);

      // R7 R12 restart mode
      wr(4'd0, 32'h0);
      wr(4'd0, 32'h043);
      ticks(0, 2);
      chk(4'd9, 32'h2, "R7 pre-count");
      wr(4'd4, 32'h3);
      chk(4'd9, 32'h0, "R12 cmp1 write clears");
      ticks(0, 3);
      chk(4'd9, 32'h3, "R7 reach cmp1");
      chk(4'd2, 32'h01, "R6 cmp1 flag");
      ticks(0, 1);
      chk(4'd9, 32'h0, "R7 restart");
      ticks(0, 2);
      chk(4'd9, 32'h2, "R7 after restart");
      wr(4'd2, 32'h3F);

      // R8 free-run rollover
      wr(4'd0, 32'h0);
      wr(4'd0, 32'h243);
      ticks(0, 255);
      chk(4'd9, 32'hFF, "R8 at top");
      chk(4'd2, 32'h07, "R6 flags passed");
      ticks(0, 1);
      chk(4'd9, 32'h0, "R8 wrapped");
      chk(4'd2, 32'h27, "R8 rollover flag");

      // R10 enable gates irq; R11 hold and resume
      wr(4'd3, 32'h20);
      chk_irq(1'b1, "R10 rov irq");
      wr(4'd0, 32'h242);
      chk_irq(1'b0, "R10 disabled");
      wr(4'd0, 32'h243);
      ticks(0, 4);
      chk(4'd9, 32'h4, "R11 running");
      wr(4'd0, 32'h242);
      ticks(0, 3);
      chk(4'd9, 32'h4, "R11 held");
      wr(4'd0, 32'h243);
      chk(4'd9, 32'h0, "R11 enable-mode restart");
      ticks(0, 2);
      wr(4'd0, 32'h242);
      wr(4'd0, 32'h241);
      chk(4'd9, 32'h2, "R11 resume keeps");
      ticks(0, 1);
      chk(4'd9, 32'h3, "R11 resumed");

      // R13 software reset
      wr(4'd1, 32'h5);
      wr(4'd3, 32'h3F);
      wr(4'd5, 32'h9);
      wr(4'd0, 32'h0013_83EB);
      chk_now(4'd0, 32'h0013_83EB, "R13 bit visible");
      chk(4'd0, 32'h0003_01EB, "R13 ctrl kept");
      chk(4'd1, 32'h0, "R13 pre");
      chk(4'd3, 32'h0, "R13 ien");
      chk(4'd2, 32'h0, "R13 stat");
      chk(4'd5, 32'hFF, "R13 cmp2");
      chk(4'd9, 32'h0, "R13 cnt");

      // R1 hardware reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk(4'd0, 32'h0, "R1 ctrl after reset");
      chk(4'd4, 32'hFF, "R1 cmp1 after reset");

      summary();
   end
endmodule